// File: doc/BRIEF.md
# Byte-Masked Burst Memory Data Path

This block is the storage and read/write data path behind a synchronous burst memory controller. Each cycle the controller hands it an already-registered word address, a select flag, and the raw active-low write enables: one global write enable, one byte-write master enable, and one enable per byte lane. The block decodes these into a per-lane write mask, updates a small word-addressed array made of four 8-bit lanes, and returns read data at the data port.

Read timing is picked by a static mode input. In pipelined mode the array output passes through two registers. In flow-through mode it passes through one register, so data arrives one cycle earlier. The bus drive enable is registered from the cycle type. A write cycle forces it off, and a deselect turns it off after one cycle. An asynchronous active-low output enable gates it without waiting for a clock edge.

Top module: `burst_sram_datapath`

## Requirements
- R1: When `gw_ni` is low on a selected cycle, all four lanes of the addressed word take `wdata_i`, whatever `bwe_ni` and `bw_ni` are.
- R2: When `gw_ni` is high and `bwe_ni` is low, lane n (bits 8n+7..8n) is written exactly when `bw_ni[n]` is low. Other lanes keep their contents.
- R3: A selected cycle with `gw_ni` high and either `bwe_ni` high or `bw_ni` all high is a read. The array is left unchanged.
- R4: In pipelined mode (`flow_ni` high), a read sampled on edge E presents the word on `dq_o` with `dq_oe_o` high after edge E+1. After edge E the bus is still off if no earlier read was pending.
- R5: In flow-through mode (`flow_ni` low), a read sampled on edge E presents the word with `dq_oe_o` high right after edge E.
- R6: After an edge that samples a write, `dq_oe_o` is low for that cycle, even with `oe_ni` low.
- R7: A deselect (`sel_i` low) sampled on edge E: in flow-through mode the bus is off after E. In pipelined mode the read from edge E-1 is still presented after E, and the bus is off after E+1.
- R8: `oe_ni` high forces `dq_oe_o` low at once. Bringing it low restores the drive with no clock edge in between.
- R9: While `rst_ni` is low, and after its release until a read is sampled, `dq_oe_o` is low.
- R10: Write data is taken from `wdata_i` on the same edge that samples the write enables. A read on the next cycle returns the updated word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | Cycle select; low is a deselect |
| addr_i | input | AW | Registered word address |
| gw_ni | input | 1 | Global write enable, active low |
| bwe_ni | input | 1 | Byte-write master enable, active low |
| bw_ni | input | NLANE | Per-lane write enables, active low |
| wdata_i | input | NLANE*LW | Write data |
| flow_ni | input | 1 | Low selects flow-through, high selects pipelined |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| dq_o | output | NLANE*LW | Read data |
| dq_oe_o | output | 1 | Bus drive enable; low means high-impedance |

## Verification
The hardest behaviour to reach from the ports is the pipelined tail. A read is followed by a deselect, the data must still be on the bus for exactly one cycle, and then it must be released. Inside that one-cycle window the output enable is also toggled between clock edges. The bench reaches this by pairing every pipelined read with two deselect cycles. It sets `oe_ni` in the middle of the cycle in which data is valid. It also sweeps all sixteen lane masks at every address, alternating the read mode by address, and issues back-to-back pipelined reads so that two words are in flight at once.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_e;
endpackage

// File: rtl/sram_we_decode.sv
module sram_we_decode
  import burst_sram_pkg::*;
#(
  parameter int unsigned NLANE = 4
) (
  input  logic             sel_i,
  input  logic             gw_ni,
  input  logic             bwe_ni,
  input  logic [NLANE-1:0] bw_ni,
  output logic [NLANE-1:0] we_o,
  output cyc_e             cyc_o
);
  logic [NLANE-1:0] lane_req;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    // global write overrides; otherwise byte enables count only under bwe
    assign lane_req[l] = !gw_ni || (!bwe_ni && !bw_ni[l]);
  end

  assign we_o = sel_i ? lane_req : '0;

  always_comb begin
    if (!sel_i)         cyc_o = CYC_IDLE;
    else if (|lane_req) cyc_o = CYC_WRITE;
    else                cyc_o = CYC_READ;
  end
endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned AW    = 4,
  parameter int unsigned NLANE = 4,
  parameter int unsigned LW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NLANE-1:0]    we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [NLANE*LW-1:0] wdata_i,
  output logic [NLANE*LW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    logic [LW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i[l]) mem_q[addr_i] <= wdata_i[l*LW +: LW];
    end

    assign rdata_o[l*LW +: LW] = mem_q[addr_i];

    // R1 R2 R10
    lane_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i[l] |=> (mem_q[$past(addr_i)] == $past(wdata_i[l*LW +: LW])));
  end
endmodule

// File: rtl/sram_rd_pipe.sv
module sram_rd_pipe #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          flow_ni,
  input  logic          oe_ni,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);
  logic [DW-1:0] s1_q, s2_q;
  logic          v1_q, v2_q, wr_q;
  logic          vld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      v1_q <= 1'b0;
      v2_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      v1_q <= rd_i;
      if (rd_i) s1_q <= rdata_i;
      v2_q <= v1_q;
      s2_q <= s1_q;
      wr_q <= wr_i;
    end
  end

  // flow-through taps the first register, pipelined the second
  assign dq_o    = flow_ni ? s2_q : s1_q;
  assign vld     = flow_ni ? v2_q : v1_q;
  assign dq_oe_o = vld && !wr_q && !oe_ni;

  // R8
  always_comb begin
    if (oe_ni === 1'b1) oe_async_chk: assert (!dq_oe_o);
  end
endmodule

// File: rtl/burst_sram_datapath.sv
module burst_sram_datapath
  import burst_sram_pkg::*;
#(
  parameter int unsigned AW    = 4,
  parameter int unsigned NLANE = 4,
  parameter int unsigned LW    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sel_i,
  input  logic [AW-1:0]       addr_i,
  input  logic                gw_ni,
  input  logic                bwe_ni,
  input  logic [NLANE-1:0]    bw_ni,
  input  logic [NLANE*LW-1:0] wdata_i,
  input  logic                flow_ni,
  input  logic                oe_ni,
  output logic [NLANE*LW-1:0] dq_o,
  output logic                dq_oe_o
);
  localparam int unsigned DW = NLANE * LW;

  logic [NLANE-1:0] we;
  cyc_e             cyc;
  logic [DW-1:0]    arr_rdata;
  logic             rd_fire, wr_fire;

  sram_we_decode #(.NLANE(NLANE)) u_dec (
    .sel_i  (sel_i),
    .gw_ni  (gw_ni),
    .bwe_ni (bwe_ni),
    .bw_ni  (bw_ni),
    .we_o   (we),
    .cyc_o  (cyc)
  );

  assign rd_fire = (cyc == CYC_READ);
  assign wr_fire = (cyc == CYC_WRITE);

  sram_lane_array #(.AW(AW), .NLANE(NLANE), .LW(LW)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  sram_rd_pipe #(.DW(DW)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_fire),
    .wr_i    (wr_fire),
    .rdata_i (arr_rdata),
    .flow_ni (flow_ni),
    .oe_ni   (oe_ni),
    .dq_o    (dq_o),
    .dq_oe_o (dq_oe_o)
  );

  // R6
  wr_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |=> !dq_oe_o);

  // R7
  desel_flow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && !flow_ni) |=> (flow_ni || !dq_oe_o));

  // R7
  desel_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i && flow_ni) ##1 (!sel_i && flow_ni) |=> (!flow_ni || !dq_oe_o));

  // R5
  flow_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && !flow_ni) |=> (flow_ni || oe_ni || dq_oe_o));

  // R4
  pipe_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && flow_ni) ##1 (!wr_fire && flow_ni) |=> (!flow_ni || oe_ni || dq_oe_o));
endmodule

// File: tb/burst_sram_datapath_test.sv
module burst_sram_datapath_test;
  localparam int unsigned AW = 4;
  localparam int unsigned NLANE = 4;
  localparam int unsigned LW = 8;
  localparam int unsigned DW = NLANE * LW;
  localparam int unsigned DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sel = 1'b0, gw_n = 1'b1, bwe_n = 1'b1, flow_n = 1'b1, oe_n = 1'b0;
  logic [NLANE-1:0] bw_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dq;
  logic dq_oe;

  logic [DW-1:0] ref_mem [DEPTH];
  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  burst_sram_datapath #(.AW(AW), .NLANE(NLANE), .LW(LW)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel), .addr_i(addr),
    .gw_ni(gw_n), .bwe_ni(bwe_n), .bw_ni(bw_n), .wdata_i(wdata),
    .flow_ni(flow_n), .oe_ni(oe_n), .dq_o(dq), .dq_oe_o(dq_oe)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // drive at negedge, return 5 ns after the sampling edge
  task automatic step(input logic s, input logic g, input logic b,
                      input logic [NLANE-1:0] w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d);
    @(negedge clk);
    sel = s; gw_n = g; bwe_n = b; bw_n = w; addr = a; wdata = d;
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 1'b1, '1, '0, '0);
  endtask

  task automatic rd_word(input logic [AW-1:0] a, input string tag);
    step(1'b1, 1'b1, 1'b1, '1, a, '0);
    if (!flow_n) begin
      chk({tag, " R5 oe"}, {31'd0, dq_oe}, 32'd1);
      chk({tag, " R5 data"}, dq, ref_mem[a]);
      idle();
      chk({tag, " R7 flow desel"}, {31'd0, dq_oe}, 32'd0);
    end else begin
      chk({tag, " R4 early"}, {31'd0, dq_oe}, 32'd0);
      idle();
      chk({tag, " R4 R7 oe"}, {31'd0, dq_oe}, 32'd1);
      chk({tag, " R4 data"}, dq, ref_mem[a]);
      idle();
      chk({tag, " R7 pipe release"}, {31'd0, dq_oe}, 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #15;
    chk("R9 in reset", {31'd0, dq_oe}, 32'd0);
    #20 rst_ni = 1'b1;
    idle();
    chk("R9 after reset", {31'd0, dq_oe}, 32'd0);

    // R1: global write with every lane enable high
    for (int a = 0; a < DEPTH; a++) begin
      logic [DW-1:0] d;
      d = 32'h0101_0101 * (a + 1) ^ 32'hA500_3C00;
      flow_n = a[0];
      step(1'b1, 1'b0, 1'b1, 4'b1111, a[AW-1:0], d);
      ref_mem[a] = d;
      chk("R6 gw release", {31'd0, dq_oe}, 32'd0);
    end
    for (int a = 0; a < DEPTH; a++) begin
      flow_n = a[1];
      rd_word(a[AW-1:0], "R1 fill");
    end

    // R2 R3 R10: every lane mask at every address
    for (int a = 0; a < DEPTH; a++) begin
      flow_n = a[0];
      for (int m = 0; m < 16; m++) begin
        logic [DW-1:0] d;
        d = 32'h9E37_79B9 * (a * 16 + m + 1);
        step(1'b1, 1'b1, 1'b0, m[NLANE-1:0], a[AW-1:0], d);
        if (m != 15) begin
          chk("R6 byte release", {31'd0, dq_oe}, 32'd0);
          for (int l = 0; l < NLANE; l++)
            if (!m[l]) ref_mem[a][l*LW +: LW] = d[l*LW +: LW];
        end else if (!flow_n) begin
          chk("R3 all-high read", dq, ref_mem[a]);
        end
        if (m != 15) rd_word(a[AW-1:0], "R2 R10 readback");
        else begin
          idle();
          if (flow_n) begin
            chk("R3 all-high pipe data", dq, ref_mem[a]);
            idle();
          end
        end
      end
    end

    // R3: master byte enable high blocks lane enables
    flow_n = 1'b0;
    for (int a = 0; a < DEPTH; a += 3) begin
      step(1'b1, 1'b1, 1'b1, 4'b0000, a[AW-1:0], 32'hDEAD_BEEF);
      chk("R3 bwe high is read", dq, ref_mem[a]);
      idle();
      rd_word(a[AW-1:0], "R3 unchanged");
    end

    // R1: global write overrides master byte enable high and mixed lanes
    step(1'b1, 1'b0, 1'b1, 4'b0101, 4'd7, 32'h1234_5678);
    ref_mem[7] = 32'h1234_5678;
    chk("R1 R6 release", {31'd0, dq_oe}, 32'd0);
    rd_word(4'd7, "R1 override");

    // R4: back-to-back pipelined reads
    flow_n = 1'b1;
    idle(); idle();
    step(1'b1, 1'b1, 1'b1, '1, 4'd2, '0);
    chk("R4 b2b early", {31'd0, dq_oe}, 32'd0);
    step(1'b1, 1'b1, 1'b1, '1, 4'd9, '0);
    chk("R4 b2b first", dq, ref_mem[2]);
    idle();
    chk("R4 b2b second", dq, ref_mem[9]);
    chk("R7 b2b still on", {31'd0, dq_oe}, 32'd1);
    idle();
    chk("R7 b2b off", {31'd0, dq_oe}, 32'd0);

    // R8: asynchronous output enable inside a valid data window
    for (int a = 0; a < DEPTH; a += 5) begin
      step(1'b1, 1'b1, 1'b1, '1, a[AW-1:0], '0);
      idle();
      chk("R8 on before", {31'd0, dq_oe}, 32'd1);
      oe_n = 1'b1; #1;
      chk("R8 async off", {31'd0, dq_oe}, 32'd0);
      oe_n = 1'b0; #1;
      chk("R8 async on", {31'd0, dq_oe}, 32'd1);
      chk("R8 data held", dq, ref_mem[a]);
      idle();
    end

    // R6: write right after a pipelined read releases the bus
    step(1'b1, 1'b1, 1'b1, '1, 4'd4, '0);
    step(1'b1, 1'b0, 1'b1, '1, 4'd4, 32'hCAFE_F00D);
    ref_mem[4] = 32'hCAFE_F00D;
    chk("R6 write after read", {31'd0, dq_oe}, 32'd0);
    idle();
    rd_word(4'd4, "R10 write after read");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule